// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write-side front end of a byte-wide nonvolatile memory that has a page buffer. A single clock samples the active-low chip-enable, write-enable and output-enable strobes, the 17-bit address and the 8-bit data bus. Each write strobe pair loads one byte into a 128-byte page buffer and restarts a load-window timer. When the window runs out with no further byte, the controller enters a commit phase of programmable length. At the end of that phase it copies the buffered bytes into an internal array model.

While a load or commit is in progress, any read returns a status word instead of array data. The host can poll for completion with three bits of that word. One bit complements the last written MSB. One bit inverts on each read access. One bit shows whether the commit has started. Once the commit ends, reads return array contents again.

The array model keeps only a parameterised number of pages, selected by the low bits of the page address, so that elaboration stays small. Reads drive an output-enable flag together with the data; a released bus shows as the flag low with the data at zero.

Top module: `pwl_ctrl`

## Requirements
- R1: After reset, data_oe_o is 0, data_o is 0, and every array location reads 8'hFF.
- R2: A byte is loaded only by a write access, which is active while ce_ni and we_ni are both 0 and oe_ni is 1. Strobe patterns with oe_ni at 0, or with ce_ni at 1, load nothing and start no load window.
- R3: The address is taken on the clock where the write access becomes active, whichever strobe fell last. The data is taken on the clock where the access ends, whichever strobe rose first. Address changes after the start and data changes before the end have no effect.
- R4: addr_i[16:7] is the page and addr_i[6:0] the byte offset. The array keeps 8 pages, indexed by the page's low 3 bits, so pages differing only above bit 9 alias.
- R5: Every loaded byte restarts the load window. The controller enters commit exactly LOAD_WIN clock edges after the edge that ended the last write access. The window does not count while a write access is active.
- R6: The commit lasts BUSY_CYC clock edges. On its last edge the buffered bytes are written into the array, and reads then return array data.
- R7: During the load window, status bit 5 reads 0. During the commit it reads 1.
- R8: While loading or committing, a read returns a status word. Bit 7 is the complement of bit 7 of the last loaded byte. Bit 6 inverts at the start of every read access. Bits 4:0 are 0.
- R9: A read access is ce_ni=0, oe_ni=0, we_ni=1. data_oe_o and data_o follow the read sampled on the previous clock. With no read sampled, data_oe_o is 0 and data_o is 0.
- R10: A byte whose page differs from the first byte of the current load is stored at its offset in the first byte's page.
- R11: Write accesses that end during the commit are ignored.
- R12: Offsets not loaded during a page write keep their previous array content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 17 | Byte address: page in [16:7], offset in [6:0] |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status word |
| data_oe_o | output | 1 | High while data_o is driven |

## Verification
A read is sampled on a rising edge, and its data or status appears after that same edge, so it is due one cycle after the strobes are applied.

The commit flag rises LOAD_WIN edges after the edge that ends the last write access. Array data returns BUSY_CYC edges after that. A reference model advances on each rising edge using the same inputs, and the outputs are compared on every falling edge.

Stimulus changes only on falling edges, so no input moves at a sampling edge. Directed checks sample on the falling edge that follows the read cycle.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } pwl_state_e;
endpackage

// File: rtl/pwl_strobe.sv
module pwl_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic wr_act_o,
  output logic wr_start_o,
  output logic wr_end_o,
  output logic rd_act_o,
  output logic rd_start_o
);
  logic wr_q, rd_q;

  assign wr_act_o   = ~ce_ni & ~we_ni & oe_ni;
  assign rd_act_o   = ~ce_ni & ~oe_ni & we_ni;
  assign wr_start_o = wr_act_o & ~wr_q;
  assign wr_end_o   = ~wr_act_o & wr_q;
  assign rd_start_o = rd_act_o & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act_o;
      rd_q <= rd_act_o;
    end
  end
endmodule

// File: rtl/pwl_page_buf.sv
module pwl_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [OFF_W-1:0]                      off_i,
  input  logic [DATA_W-1:0]                     data_i,
  input  logic                                  clr_i,
  output logic [(1<<OFF_W)-1:0][DATA_W-1:0]     buf_o,
  output logic [(1<<OFF_W)-1:0]                 valid_o
);
  localparam int PAGE_BYTES = 1 << OFF_W;

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_o[b]   <= '0;
        valid_o[b] <= 1'b0;
      end else if (clr_i) begin
        valid_o[b] <= 1'b0;
      end else if (wr_en_i && off_i == OFF_W'(b)) begin
        buf_o[b]   <= data_i;
        valid_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwl_array.sv
module pwl_array #(
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int ARR_PG_W = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [OFF_W+ARR_PG_W-1:0]         rd_idx_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  input  logic                              commit_i,
  input  logic [ARR_PG_W-1:0]               commit_pg_i,
  input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] buf_i,
  input  logic [(1<<OFF_W)-1:0]             valid_i
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int DEPTH      = 1 << (OFF_W + ARR_PG_W);

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_idx_i];

  // erased state is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        if (valid_i[j]) mem_q[{commit_pg_i, OFF_W'(j)}] <= buf_i[j];
      end
    end
  end
endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int ARR_PG_W = 3,
  parameter int LOAD_WIN = 16,
  parameter int BUSY_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int IDX_W      = OFF_W + ARR_PG_W;
  localparam int TMR_W      = $clog2(LOAD_WIN + 1);
  localparam int BSY_W      = $clog2(BUSY_CYC + 1);
  localparam int MSB        = DATA_W - 1;

  logic wr_act, wr_start, wr_end, rd_act, rd_start;
  pwl_state_e state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [BSY_W-1:0] bsy_q;
  logic [IDX_W-1:0] addr_q;
  logic [ARR_PG_W-1:0] page_q;
  logic msb_q, tog_q, tog_nx;
  logic load_en, commit_done, busy;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf;
  logic [PAGE_BYTES-1:0] pvalid;
  logic [DATA_W-1:0] arr_rd, stat_w, data_d;
  logic unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_W];

  pwl_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .wr_act_o   (wr_act),
    .wr_start_o (wr_start),
    .wr_end_o   (wr_end),
    .rd_act_o   (rd_act),
    .rd_start_o (rd_start)
  );

  assign load_en     = wr_end && (state_q != ST_COMMIT);
  assign commit_done = (state_q == ST_COMMIT) && (bsy_q == BSY_W'(1));
  assign busy        = (state_q != ST_IDLE);

  pwl_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (load_en),
    .off_i   (addr_q[OFF_W-1:0]),
    .data_i  (data_i),
    .clr_i   (commit_done),
    .buf_o   (pbuf),
    .valid_o (pvalid)
  );

  pwl_array #(.DATA_W(DATA_W), .OFF_W(OFF_W), .ARR_PG_W(ARR_PG_W)) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (addr_i[IDX_W-1:0]),
    .rd_data_o   (arr_rd),
    .commit_i    (commit_done),
    .commit_pg_i (page_q),
    .buf_i       (pbuf),
    .valid_i     (pvalid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (wr_start) addr_q <= addr_i[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      bsy_q   <= '0;
      page_q  <= '0;
      msb_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_COMMIT: begin
          if (commit_done) state_q <= ST_IDLE;
          else             bsy_q   <= bsy_q - 1'b1;
        end
        default: begin
          if (wr_end) begin
            // first byte of a load fixes the page; later bytes are redirected
            if (state_q == ST_IDLE) page_q <= addr_q[IDX_W-1:OFF_W];
            msb_q   <= data_i[MSB];
            tmr_q   <= TMR_W'(LOAD_WIN);
            state_q <= ST_LOAD;
          end else if (state_q == ST_LOAD && !wr_act) begin
            if (tmr_q == TMR_W'(1)) begin
              state_q <= ST_COMMIT;
              bsy_q   <= BSY_W'(BUSY_CYC);
            end else begin
              tmr_q <= tmr_q - 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign tog_nx = tog_q ^ (rd_start & busy);

  always_comb begin
    stat_w        = '0;
    stat_w[MSB]   = ~msb_q;
    stat_w[MSB-1] = tog_nx;
    stat_w[MSB-2] = (state_q == ST_COMMIT);
    if (!rd_act)   data_d = '0;
    else if (busy) data_d = stat_w;
    else           data_d = arr_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q     <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      tog_q     <= tog_nx;
      data_o    <= data_d;
      data_oe_o <= rd_act;
    end
  end
endmodule

// File: rtl/pwl_ctrl_chk.sv
module pwl_ctrl_chk
  import pwl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TMR_W      = 5,
  parameter int LOAD_WIN   = 16,
  parameter int PAGE_BYTES = 128
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ce_ni,
  input logic                  we_ni,
  input logic                  oe_ni,
  input logic [DATA_W-1:0]     data_o,
  input logic                  data_oe_o,
  input pwl_state_e            state_q,
  input logic [TMR_W-1:0]      tmr_q,
  input logic [PAGE_BYTES-1:0] pvalid,
  input logic                  wr_end
);
  // R9
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && !oe_ni && we_ni) |=> (!data_oe_o && data_o == '0));

  // R7
  commit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT && !ce_ni && !oe_ni && we_ni) |=> data_o[DATA_W-3]);

  // R8
  status_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !ce_ni && !oe_ni && we_ni) |=> (data_o[DATA_W-4:0] == '0));

  // R5
  window_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_COMMIT && wr_end) |=> (state_q == ST_LOAD && tmr_q == TMR_W'(LOAD_WIN)));

  // R6
  commit_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT) |=> (state_q != ST_LOAD));

  // R11
  commit_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT) |=> (pvalid == $past(pvalid) || pvalid == '0));
endmodule

bind pwl_ctrl pwl_ctrl_chk #(
  .DATA_W     (DATA_W),
  .TMR_W      (TMR_W),
  .LOAD_WIN   (LOAD_WIN),
  .PAGE_BYTES (PAGE_BYTES)
) i_pwl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .state_q   (state_q),
  .tmr_q     (tmr_q),
  .pvalid    (pvalid),
  .wr_end    (wr_end)
);

// File: tb/test_pwl_ctrl.sv
module test_pwl_ctrl;
  localparam int LW = 16;
  localparam int BC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwl_ctrl #(.LOAD_WIN(LW), .BUSY_CYC(BC)) i_pwl_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // behavioural reference model
  logic [7:0] m_mem [int];
  logic [7:0] m_buf [int];
  int m_state = 0, m_tmr = 0, m_busy = 0, m_page = 0;
  logic [16:0] m_addr = '0;
  logic [7:0] m_last = '0;
  bit m_tog = 0, m_prev_wr = 0, m_prev_rd = 0;
  logic [7:0] exp_d = '0;
  logic exp_oe = 1'b0;

  function automatic logic [7:0] mem_rd(int idx);
    return m_mem.exists(idx) ? m_mem[idx] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_tog = 0; m_prev_wr = 0; m_prev_rd = 0;
      m_buf.delete(); m_mem.delete();
      exp_d = '0; exp_oe = 1'b0;
    end else begin
      bit wr, rd;
      wr = !we_n && !ce_n && oe_n;
      rd = !ce_n && !oe_n && we_n;
      if (rd) begin
        exp_oe = 1'b1;
        if (m_state != 0) begin
          if (!m_prev_rd) m_tog = !m_tog;
          exp_d = {~m_last[7], m_tog, m_state == 2, 5'b0};
        end else begin
          exp_d = mem_rd(int'(addr % 1024));
        end
      end else begin
        exp_oe = 1'b0;
        exp_d = '0;
      end
      if (wr && !m_prev_wr) m_addr = addr;
      if (m_state == 2) begin
        if (m_busy == 1) begin
          foreach (m_buf[k]) m_mem[m_page * 128 + k] = m_buf[k];
          m_buf.delete();
          m_state = 0;
        end else m_busy--;
      end else if (!wr && m_prev_wr) begin
        if (m_state == 0) m_page = int'((m_addr / 128) % 8);
        m_buf[int'(m_addr % 128)] = din;
        m_last = din;
        m_state = 1;
        m_tmr = LW;
      end else if (m_state == 1 && !wr) begin
        if (m_tmr == 1) begin
          m_state = 2;
          m_busy = BC;
        end else m_tmr--;
      end
      m_prev_wr = wr;
      m_prev_rd = rd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (dout !== exp_d || doe !== exp_oe) begin
        n_fail++;
        $display("FAIL %s: data_o=%h oe=%b expected data_o=%h oe=%b", cur_req, dout, doe, exp_d, exp_oe);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // write controlled by we_ni
  task automatic wr_we(logic [16:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = a; din = d;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(logic [16:0] a, output logic [7:0] v);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk); v = dout; ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_data(logic [16:0] a, logic [7:0] exp, string req);
    logic [7:0] v;
    bit got;
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      rd(a, v);
      if (v == exp) got = 1;
    end
    chk(req, v, exp);
  endtask

  initial begin
    logic [7:0] v, v2;
    int k;
    bit got;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 oe after reset", {7'b0, doe}, 8'h00);
    chk("R1 data after reset", dout, 8'h00);
    rd(17'h00005, v);
    chk("R1 erased read", v, 8'hFF);
    cur_req = "R9";
    @(negedge clk);
    chk("R9 released oe", {7'b0, doe}, 8'h00);

    // page write with bytes spaced past one window length in total
    cur_req = "R5";
    wr_we(17'h00180, 8'h12);
    idle(10);
    wr_we(17'h00181, 8'h34);
    idle(10);
    wr_we(17'h00185, 8'hA5);
    cur_req = "R8";
    rd(17'h00180, v);
    rd(17'h00180, v2);
    chk("R7 window flag", {7'b0, v[5]}, 8'h00);
    chk("R8 inverted msb", {7'b0, v[7]}, 8'h00);
    chk("R8 toggle differs", {7'b0, v[6] ^ v2[6]}, 8'h01);
    chk("R8 low bits zero", {3'b0, v[4:0]}, 8'h00);
    cur_req = "R7";
    got = 0;
    for (int i = 0; i < 100 && !got; i++) begin
      rd(17'h00180, v);
      if (v[5]) got = 1;
    end
    chk("R7 commit flag", {7'b0, v[5]}, 8'h01);
    cur_req = "R11";
    wr_we(17'h00187, 8'h77);
    cur_req = "R6";
    wait_data(17'h00180, 8'h12, "R6 commit result");
    rd(17'h00181, v);
    chk("R6 byte 1", v, 8'h34);
    rd(17'h00185, v);
    chk("R4 offset 5", v, 8'hA5);
    rd(17'h00187, v);
    chk("R11 ignored write", v, 8'hFF);
    rd(17'h00182, v);
    chk("R12 untouched offset", v, 8'hFF);

    // exact window length with a held read
    cur_req = "R5";
    wr_we(17'h00380, 8'h01);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = 17'h00380;
    k = 0;
    got = 0;
    while (!got && k < 100) begin
      @(negedge clk);
      k++;
      if (dout[5]) got = 1;
    end
    chk("R5 window cycles", 8'(k), 8'(LW));
    chk("R8 msb complement", {7'b0, dout[7]}, 8'h01);
    ce_n = 1; oe_n = 1;
    cur_req = "R6";
    wait_data(17'h00380, 8'h01, "R6 single byte");

    // chip-enable controlled write, late address/data changes
    cur_req = "R3";
    @(negedge clk); we_n = 0; oe_n = 1; ce_n = 1; addr = 17'h00289; din = 8'h11;
    @(negedge clk); ce_n = 0;
    @(negedge clk); addr = 17'h0000C; din = 8'h22;
    @(negedge clk); din = 8'h5C;
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1;
    cur_req = "R10";
    wr_we(17'h0030A, 8'h66);
    wait_data(17'h00289, 8'h5C, "R3 captured byte");
    rd(17'h0000C, v);
    chk("R3 late address unused", v, 8'hFF);
    rd(17'h0028A, v);
    chk("R10 redirected byte", v, 8'h66);
    rd(17'h0030A, v);
    chk("R10 other page untouched", v, 8'hFF);

    // non-write strobe patterns
    cur_req = "R2";
    @(negedge clk); addr = 17'h00203; din = 8'h42; ce_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1;
    idle(30);
    rd(17'h00203, v);
    chk("R2 no load", v, 8'hFF);

    // page aliasing in the array
    cur_req = "R4";
    wr_we(17'h00582, 8'h9E);
    wait_data(17'h00582, 8'h9E, "R4 direct page");
    rd(17'h00182, v);
    chk("R4 aliased page", v, 8'h9E);
    rd(17'h00180, v);
    chk("R12 earlier byte kept", v, 8'h12);

    idle(4);
    finish_run();
  end
endmodule